// File: doc/BRIEF.md
# Tone Presence Persistence Detector

This block is the decision stage of a single-tone detector. An upstream transform delivers, once per analysis frame, two unsigned words: the energy that fell into the bin holding the wanted tone and the energy summed over every bin of that frame. The block decides whether the bin's share of the frame energy is large enough to call the frame a hit. It makes this decision with a multiply-and-compare instead of a divider.

Single hits are not trusted on their own. Every frame's verdict is pushed into a window that holds the most recent `WIN_LEN` verdicts. A running tally of the hits inside that window is kept. The tone is reported as present while the tally is strictly above a programmable count limit. A tone that persists for several frames is therefore accepted, while isolated noise hits are rejected.

The ratio limit is an unsigned fixed-point fraction with `QF` fraction bits. With the default `QF = 8`, the value 128 stands for one half and 256 stands for one.

Top module: `tone_persist_detect`

## Requirements
- R1: While `rst_n` is low, and after it is released, `hit_count` is 0 and `detect` is 0, and the verdict window holds no hits.
- R2: A frame with a nonzero total is a hit exactly when `bin_energy * 2^QF > ratio_thr * total_energy`, with no truncation of either product (QF = 8 by default). Equality is a miss.
- R3: A frame whose `total_energy` is zero is always a miss, whatever `bin_energy` and `ratio_thr` hold.
- R4: After each frame, `hit_count` equals the number of hits among the last `WIN_LEN` frames (default 16). The oldest verdict leaves the window as the new one enters.
- R5: `hit_count` and `detect` change only on a rising edge at which `frame_valid` is high, and take their new values on that edge. With `frame_valid` low they hold.
- R6: On each frame, `detect` becomes 1 when the updated count is strictly greater than `count_thr`, and 0 when the count is at or below it.
- R7: `hit_count` never exceeds `WIN_LEN`, and it moves by at most one per frame.
- R8: When the entering verdict and the leaving verdict are both hits, the count is unchanged. This also holds with a full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | One-cycle strobe: the energy words belong to a new frame |
| bin_energy | input | EW (24) | Energy in the target bin |
| total_energy | input | EW (24) | Energy summed over all bins |
| ratio_thr | input | QF+1 (9) | Share limit, unsigned with QF fraction bits |
| count_thr | input | CW (5) | Tally must exceed this for detection |
| detect | output | 1 | Tone present |
| hit_count | output | CW (5) | Hits in the current window |

## Verification
On a single frame strobe, a verdict enters the window and the oldest verdict leaves it. The count update must then handle both an addition and a removal on the same edge. The bench provokes this by filling the window completely with hits and then sending further hits: the count must stay at `WIN_LEN`. It then sends a miss, and the count must drop by exactly one. In that same cycle the count crosses `count_thr`, so the bench also checks that `detect` falls on the very edge at which the count drops to the limit.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  typedef enum logic {
    VERDICT_MISS = 1'b0,
    VERDICT_HIT  = 1'b1
  } verdict_e;

  // movement of the tally for one entering and one leaving verdict
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  function automatic step_e tally_step(input verdict_e enter, input verdict_e leave);
    if (enter == leave) return STEP_HOLD;
    return (enter == VERDICT_HIT) ? STEP_UP : STEP_DOWN;
  endfunction
endpackage

// File: rtl/tpd_ratio_cmp.sv
module tpd_ratio_cmp #(
  parameter int EW = 24,
  parameter int QF = 8,
  parameter int TW = QF + 1
) (
  input  logic [EW-1:0] bin_energy,
  input  logic [EW-1:0] total_energy,
  input  logic [TW-1:0] ratio_thr,
  output tpd_pkg::verdict_e verdict
);
  localparam int SH = (QF > TW) ? QF : TW;
  localparam int PW = EW + SH;

  // share test by cross-multiplication; products sized to never wrap
  function automatic tpd_pkg::verdict_e share_test(
    input logic [EW-1:0] b, input logic [EW-1:0] t, input logic [TW-1:0] r);
    logic [PW-1:0] scaled_bin;
    logic [PW-1:0] scaled_tot;
    scaled_bin = {{SH{1'b0}}, b} << QF;
    scaled_tot = {{SH{1'b0}}, t} * {{(PW-TW){1'b0}}, r};
    if (t == '0) return tpd_pkg::VERDICT_MISS;
    return (scaled_bin > scaled_tot) ? tpd_pkg::VERDICT_HIT : tpd_pkg::VERDICT_MISS;
  endfunction

  always_comb verdict = share_test(bin_energy, total_energy, ratio_thr);

  // R3
  always_comb begin
    empty_frame_miss_chk: assert (total_energy != '0 || verdict == tpd_pkg::VERDICT_MISS);
  end
endmodule

// File: rtl/tpd_window.sv
module tpd_window #(
  parameter int WIN_LEN = 16,
  parameter int CW = $clog2(WIN_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  tpd_pkg::verdict_e enter,
  output logic [CW-1:0]     count,
  output logic [CW-1:0]     count_next
);
  import tpd_pkg::*;

  logic [WIN_LEN-1:0] history;
  verdict_e leave;
  step_e    step;

  assign leave = verdict_e'(history[WIN_LEN-1]);
  assign step  = tally_step(enter, leave);

  always_comb begin
    unique case (step)
      STEP_UP:   count_next = count + CW'(1);
      STEP_DOWN: count_next = count - CW'(1);
      default:   count_next = count;
    endcase
  end

  generate
    if (WIN_LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)        history <= '0;
        else if (shift_en) history <= enter;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n)        history <= '0;
        else if (shift_en) history <= {history[WIN_LEN-2:0], enter};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        count <= '0;
    else if (shift_en) count <= count_next;
  end

  // R4
  tally_matches_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count == CW'($countones(history)));
  // R7
  tally_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(WIN_LEN));
  // R8
  both_hits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && enter == VERDICT_HIT && leave == VERDICT_HIT) |=> $stable(count));
endmodule

// File: rtl/tpd_decide.sv
module tpd_decide #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          update,
  input  logic [CW-1:0] count_next,
  input  logic [CW-1:0] count_thr,
  output logic          detect
);
  always_ff @(posedge clk) begin
    if (!rst_n)      detect <= 1'b0;
    else if (update) detect <= (count_next > count_thr);
  end
endmodule

// File: rtl/tone_persist_detect.sv
module tone_persist_detect #(
  parameter int EW = 24,
  parameter int QF = 8,
  parameter int TW = QF + 1,
  parameter int WIN_LEN = 16,
  parameter int CW = $clog2(WIN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_valid,
  input  logic [EW-1:0] bin_energy,
  input  logic [EW-1:0] total_energy,
  input  logic [TW-1:0] ratio_thr,
  input  logic [CW-1:0] count_thr,
  output logic          detect,
  output logic [CW-1:0] hit_count
);
  tpd_pkg::verdict_e frame_verdict;
  logic [CW-1:0]     tally_next;

  tpd_ratio_cmp #(.EW(EW), .QF(QF), .TW(TW)) u_cmp (
    .bin_energy   (bin_energy),
    .total_energy (total_energy),
    .ratio_thr    (ratio_thr),
    .verdict      (frame_verdict)
  );

  tpd_window #(.WIN_LEN(WIN_LEN), .CW(CW)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (frame_valid),
    .enter      (frame_verdict),
    .count      (hit_count),
    .count_next (tally_next)
  );

  tpd_decide #(.CW(CW)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .update     (frame_valid),
    .count_next (tally_next),
    .count_thr  (count_thr),
    .detect     (detect)
  );

  // R5
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> ($stable(hit_count) && $stable(detect)));
  // R6
  detect_tracks_tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> (detect == (hit_count > $past(count_thr))));
  // R3
  empty_frame_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && total_energy == '0) |=> (hit_count <= $past(hit_count)));
  // R7
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> ((hit_count == $past(hit_count)) ||
                     (hit_count == $past(hit_count) + CW'(1)) ||
                     (hit_count + CW'(1) == $past(hit_count))));
endmodule

// File: tb/tb_tone_persist_detect.sv
module tb_tone_persist_detect;
  localparam int EW = 24, QF = 8, TW = 9, WL = 16, CW = 5;

  typedef struct packed {
    logic [EW-1:0] bin;
    logic [EW-1:0] tot;
    logic [TW-1:0] thr;
    logic          hit;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{24'h000100, 24'h000200, 9'd128, 1'b0},  // R2 equality is a miss
    '{24'h000101, 24'h000200, 9'd128, 1'b1},  // R2 just above
    '{24'h000005, 24'h000000, 9'd0,   1'b0},  // R3 empty frame
    '{24'hFFFFFF, 24'hFFFFFF, 9'd256, 1'b0},  // R2 full scale, share one
    '{24'hFFFFFF, 24'hFFFFFF, 9'd255, 1'b1},  // R2 full scale hit
    '{24'h000001, 24'hFFFFFF, 9'd0,   1'b1},  // R2 zero limit
    '{24'h000000, 24'h00000A, 9'd0,   1'b0},  // R2 zero bin
    '{24'h000003, 24'h000064, 9'd8,   1'b0},  // R2 768 vs 800
    '{24'h000004, 24'h000064, 9'd8,   1'b1},  // R2 1024 vs 800
    '{24'h0003E8, 24'h0003E8, 9'd200, 1'b1}   // R2
  };

  logic clk = 0, rst_n = 0, frame_valid = 0;
  logic [EW-1:0] bin_energy = '0, total_energy = '0;
  logic [TW-1:0] ratio_thr = '0;
  logic [CW-1:0] count_thr = 5'd2;
  logic detect;
  logic [CW-1:0] hit_count;
  int errors = 0, checks = 0;
  logic [WL-1:0] model = '0;

  always #2 clk = ~clk;

  tone_persist_detect dut (.*);

  task automatic check(string req, logic [CW-1:0] exp_cnt, logic exp_det);
    checks++;
    if (hit_count !== exp_cnt || detect !== exp_det) begin
      errors++;
      $display("FAIL %s: count=%0d det=%0b expected count=%0d det=%0b",
               req, hit_count, detect, exp_cnt, exp_det);
    end
  endtask

  task automatic send(logic [EW-1:0] b, logic [EW-1:0] t, logic [TW-1:0] r, logic h);
    @(negedge clk);
    bin_energy = b; total_energy = t; ratio_thr = r; frame_valid = 1;
    @(negedge clk);
    frame_valid = 0;
    model = {model[WL-2:0], h};
  endtask

  function automatic logic [CW-1:0] mcount();
    return CW'($countones(model));
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 0, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", 0, 0);

    foreach (VECS[i]) begin
      send(VECS[i].bin, VECS[i].tot, VECS[i].thr, VECS[i].hit);
      check("R2/R4/R6", mcount(), mcount() > count_thr);
    end

    // R5: idle cycles with hitting inputs change nothing
    bin_energy = 24'd50; total_energy = 24'd50; ratio_thr = 9'd1; count_thr = 5'd0;
    repeat (4) @(negedge clk);
    check("R5", 5, 1'b1);  // detect still from last frame with thr 2
    count_thr = 5'd2;

    // R3: many empty frames with large bin
    for (int k = 0; k < 3; k++) begin
      send(24'hFFFFFF, 24'd0, 9'd0, 1'b0);
      check("R3", mcount(), mcount() > count_thr);
    end

    // R4/R7/R8: fill with hits, then keep feeding hits
    count_thr = 5'd15;
    for (int k = 0; k < WL + 3; k++) begin
      send(24'd9, 24'd10, 9'd128, 1'b1);
      check("R4", mcount(), mcount() > count_thr);
    end
    check("R7", 16, 1);
    send(24'd9, 24'd10, 9'd128, 1'b1);
    check("R8", 16, 1);

    // R6: drop to limit -> detect falls in same update
    send(24'd1, 24'd10, 9'd128, 1'b0);
    check("R6", 15, 0);
    send(24'd1, 24'd10, 9'd128, 1'b0);
    check("R7", 14, 0);
    count_thr = 5'd13;
    send(24'd9, 24'd10, 9'd128, 1'b1);
    check("R6", 14, 1);

    // R1: mid-run reset
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk);
    check("R1", 0, 0);
    rst_n = 1; model = '0; count_thr = 5'd0;
    send(24'd9, 24'd10, 9'd128, 1'b1);
    check("R1", 1, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule